// File: doc/BRIEF.md
# Masked SIMD Processing Array with Ring Routing

This block is a linear array of identical processing elements (PEs), eight by default, that all execute one broadcast instruction in the same cycle. Each PE holds a 64-bit accumulator, a 64-bit routing register, a one-bit activity flag and a private 16-word operand store. No PE fetches its own instructions. A PE can reach only its own store. Data moves between PEs only by shifting the routing registers around the ring.

The integer adder in each PE can work as one 64-bit lane, as two 32-bit lanes or as eight 8-bit lanes. A mask instruction sets or clears each activity flag. The flag can be loaded from a broadcast bit vector or from a test on the PE's own accumulator. A PE with its flag clear keeps its accumulator and its store unchanged, but it still forwards routing data. A multi-hop route can therefore pass through inactive PEs.

A controller offers one instruction with `instr_valid_i` while `instr_ready_o` is high. It then waits for the one-cycle `done_o` pulse. Every accumulator, every routing register and every activity flag is visible at the ports at all times.

Top module: `simd_array`

## Requirements
- R1: After reset, every accumulator and routing register is zero, every activity flag is set, `instr_ready_o` is high and `done_o` is low.
- R2: Opcodes (4 bits): 0 nop, 1 load immediate (acc = `imm_i`), 2 load (acc = store[addr]), 3 store (store[addr] = acc), 4 add (acc = acc + store[addr]), 5 subtract (acc = acc - store[addr]), 6 put (route reg = acc), 7 get (acc = route reg), 8 mask, 9 route; 10 to 15 act as nop. Every active PE executes the accepted instruction in the same cycle. For any opcode other than route, `done_o` pulses in the cycle after acceptance.
- R3: `lane_i` 0 selects one 64-bit lane, 1 selects two 32-bit lanes (bits 31:0 and 63:32), 2 selects eight 8-bit lanes, and 3 acts as 0. Add and subtract wrap within each lane, and no carry or borrow crosses a lane boundary.
- R4: A PE whose activity flag is clear ignores opcodes 1 to 7. Its accumulator, its store and its routing register keep their values under these opcodes.
- R5: Route moves each routing register one PE position per cycle, `route_hops_i` times. With `route_dir_i`=1, PE i takes the value of PE i-1. With `route_dir_i`=0, PE i takes the value of PE i+1. Indices wrap around the ring, and inactive PEs take part.
- R6: A route with H hops, where H ≥ 1, holds `instr_ready_o` low and raises `done_o` H cycles after acceptance. A route with H = 0 changes nothing and completes in one cycle.
- R7: Mask (opcode 8) sets the activity flag of every PE, active or not, according to `mask_mode_i`. Mode 0 takes bit i of `mask_vec_i`. Mode 1 sets the flag when the accumulator is zero. Mode 2 sets it when accumulator bit 63 is set. Mode 3 sets every flag.
- R8: A store writes only the writing PE's own store word. A later load returns that PE's own value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | 1 | Instruction offered |
| instr_ready_o | output | 1 | Array can accept an instruction |
| instr_op_i | input | 4 | Opcode |
| lane_i | input | 2 | Lane partition for add and subtract |
| addr_i | input | 4 | Word address in the local store |
| imm_i | input | 64 | Broadcast immediate |
| mask_mode_i | input | 2 | Source of the activity flags |
| mask_vec_i | input | NUM_PE | Broadcast flag vector |
| route_dir_i | input | 1 | 1: toward higher index, 0: toward lower index |
| route_hops_i | input | 4 | Hop count |
| done_o | output | 1 | Instruction complete (one-cycle pulse) |
| active_o | output | NUM_PE | Activity flags |
| acc_o | output | NUM_PE*64 | Accumulators, PE i at bits 64i+63:64i |
| route_o | output | NUM_PE*64 | Routing registers, PE i at bits 64i+63:64i |

## Verification
All PE state is brought straight to the ports. A wrong carry cut, a gating error or a misrouted hop therefore shows in `acc_o`, `route_o` or `active_o` at the first sample after the `done_o` of the instruction that caused it. The store is not visible at the ports. A wrong store write shows only when a later load or add reads that word back. The bench therefore reloads every address after the masked and unmasked store sequences. A wrong hop counter shows at once as a `done_o` that comes early or late.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    OP_NOP = 4'd0, OP_LDI = 4'd1, OP_LOAD = 4'd2, OP_STORE = 4'd3,
    OP_ADD = 4'd4, OP_SUB = 4'd5, OP_PUT = 4'd6, OP_GET = 4'd7,
    OP_MASK = 4'd8, OP_ROUTE = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    LANE_64 = 2'd0, LANE_32 = 2'd1, LANE_8 = 2'd2
  } lane_e;

  typedef enum logic [1:0] {
    MSK_VEC = 2'd0, MSK_ZERO = 2'd1, MSK_NEG = 2'd2, MSK_ALL = 2'd3
  } mask_e;
endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic [1:0]        lane_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int NSEG     = DATA_W / SEG_W;
  localparam int HALF_SEG = NSEG / 2;

  logic [SEG_W:0] part;
  logic           cy;

  // carry chain over segments, cut and re-seeded at each lane start
  always_comb begin
    cy   = sub_i;
    part = '0;
    y_o  = '0;
    for (int s = 0; s < NSEG; s++) begin
      if (s != 0 && (lane_i == LANE_8 || (lane_i == LANE_32 && (s % HALF_SEG) == 0)))
        cy = sub_i;
      part = {1'b0, a_i[s*SEG_W +: SEG_W]}
           + {1'b0, b_i[s*SEG_W +: SEG_W] ^ {SEG_W{sub_i}}}
           + {{SEG_W{1'b0}}, cy};
      y_o[s*SEG_W +: SEG_W] = part[SEG_W-1:0];
      cy = part[SEG_W];
    end
  end
endmodule

// File: rtl/simd_seq.sv
module simd_seq
  import simd_pkg::*;
#(
  parameter int HOP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [3:0]       op_i,
  input  logic             dir_i,
  input  logic [HOP_W-1:0] hops_i,
  output logic             ready_o,
  output logic             exec_o,
  output logic             shift_o,
  output logic             dir_o,
  output logic             done_o
);
  logic             busy_q, dir_q, done_q;
  logic [HOP_W-1:0] remain_q;
  logic             accept, is_route;

  assign ready_o  = !busy_q;
  assign accept   = valid_i && !busy_q;
  assign is_route = (op_i == OP_ROUTE);
  assign exec_o   = accept && !is_route;
  assign shift_o  = (accept && is_route && hops_i != '0) || busy_q;
  assign dir_o    = accept ? dir_i : dir_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      dir_q    <= 1'b0;
      remain_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= (accept && (!is_route || hops_i <= HOP_W'(1)))
             || (busy_q && remain_q == HOP_W'(1));
      if (accept && is_route) begin
        dir_q    <= dir_i;
        busy_q   <= hops_i > HOP_W'(1);
        remain_q <= hops_i - HOP_W'(1);
      end else if (busy_q) begin
        remain_q <= remain_q - HOP_W'(1);
        if (remain_q == HOP_W'(1)) busy_q <= 1'b0;
      end
    end
  end

  AST_ROUTE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && is_route && hops_i > HOP_W'(1)) |=> (busy_q && !done_q)); // R6
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q); // R6
  AST_SINGLE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |=> done_q); // R2
endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int MEM_DEPTH = 16,
  localparam int ADDR_W   = $clog2(MEM_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  logic [3:0]        op_i,
  input  logic [1:0]        lane_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [1:0]        mask_mode_i,
  input  logic              mask_bit_i,
  input  logic              shift_i,
  input  logic              dir_i,
  input  logic [DATA_W-1:0] nbr_lo_i,
  input  logic [DATA_W-1:0] nbr_hi_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] rr_o,
  output logic              act_o
);
  logic [DATA_W-1:0] mem_q [MEM_DEPTH];
  logic [DATA_W-1:0] acc_q, rr_q, rd_w, alu_y;
  logic              act_q, do_w;

  assign do_w  = exec_i && act_q;
  assign rd_w  = mem_q[addr_i];
  assign acc_o = acc_q;
  assign rr_o  = rr_q;
  assign act_o = act_q;

  simd_lane_alu #(.DATA_W(DATA_W), .SEG_W(8)) u_alu (
    .a_i(acc_q), .b_i(rd_w), .sub_i(op_i == OP_SUB), .lane_i(lane_i), .y_o(alu_y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (do_w) begin
      case (op_i)
        OP_LDI:         acc_q <= imm_i;
        OP_LOAD:        acc_q <= rd_w;
        OP_ADD, OP_SUB: acc_q <= alu_y;
        OP_GET:         acc_q <= rr_q;
        default:        ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < MEM_DEPTH; k++) mem_q[k] <= '0;
    end else if (do_w && op_i == OP_STORE) begin
      mem_q[addr_i] <= acc_q;
    end
  end

  // routing ignores the activity flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   rr_q <= '0;
    else if (shift_i)              rr_q <= dir_i ? nbr_lo_i : nbr_hi_i;
    else if (do_w && op_i == OP_PUT) rr_q <= acc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b1;
    end else if (exec_i && op_i == OP_MASK) begin
      case (mask_mode_i)
        MSK_VEC:  act_q <= mask_bit_i;
        MSK_ZERO: act_q <= (acc_q == '0);
        MSK_NEG:  act_q <= acc_q[DATA_W-1];
        default:  act_q <= 1'b1;
      endcase
    end
  end

  AST_FROZEN_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q |=> $stable(acc_q)); // R4
  AST_FROZEN_RR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_q && !shift_i) |=> $stable(rr_q)); // R4
  AST_LANE8_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_w && op_i == OP_ADD && lane_i == LANE_8)
      |=> acc_q[DATA_W-1 -: 8] == $past(acc_q[DATA_W-1 -: 8] + rd_w[DATA_W-1 -: 8])); // R3
  AST_MASK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i == OP_MASK && mask_mode_i == MSK_ZERO)
      |=> act_q == ($past(acc_q) == '0)); // R7
endmodule

// File: rtl/simd_array.sv
module simd_array
  import simd_pkg::*;
#(
  parameter int NUM_PE    = 8,
  parameter int DATA_W    = 64,
  parameter int MEM_DEPTH = 16,
  parameter int HOP_W     = 4,
  localparam int ADDR_W   = $clog2(MEM_DEPTH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     instr_valid_i,
  output logic                     instr_ready_o,
  input  logic [3:0]               instr_op_i,
  input  logic [1:0]               lane_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        imm_i,
  input  logic [1:0]               mask_mode_i,
  input  logic [NUM_PE-1:0]        mask_vec_i,
  input  logic                     route_dir_i,
  input  logic [HOP_W-1:0]         route_hops_i,
  output logic                     done_o,
  output logic [NUM_PE-1:0]        active_o,
  output logic [NUM_PE*DATA_W-1:0] acc_o,
  output logic [NUM_PE*DATA_W-1:0] route_o
);
  logic              exec_w, shift_w, dir_w;
  logic [DATA_W-1:0] rr_w [NUM_PE];

  simd_seq #(.HOP_W(HOP_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(instr_valid_i), .op_i(instr_op_i),
    .dir_i(route_dir_i), .hops_i(route_hops_i), .ready_o(instr_ready_o),
    .exec_o(exec_w), .shift_o(shift_w), .dir_o(dir_w), .done_o(done_o)
  );

  for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
    localparam int LO = (i + NUM_PE - 1) % NUM_PE;
    localparam int HI = (i + 1) % NUM_PE;

    simd_pe #(.DATA_W(DATA_W), .MEM_DEPTH(MEM_DEPTH)) u_pe (
      .clk_i(clk_i), .rst_ni(rst_ni), .exec_i(exec_w), .op_i(instr_op_i),
      .lane_i(lane_i), .addr_i(addr_i), .imm_i(imm_i), .mask_mode_i(mask_mode_i),
      .mask_bit_i(mask_vec_i[i]), .shift_i(shift_w), .dir_i(dir_w),
      .nbr_lo_i(rr_w[LO]), .nbr_hi_i(rr_w[HI]),
      .acc_o(acc_o[i*DATA_W +: DATA_W]), .rr_o(rr_w[i]), .act_o(active_o[i])
    );
    assign route_o[i*DATA_W +: DATA_W] = rr_w[i];

    AST_HOP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (shift_w && dir_w) |=> rr_w[i] == $past(rr_w[LO])); // R5
    AST_HOP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (shift_w && !dir_w) |=> rr_w[i] == $past(rr_w[HI])); // R5
  end
endmodule

// File: tb/simd_array_test.sv
module simd_array_test;
  localparam int N  = 8;
  localparam int BW = N * 64;
  localparam logic [3:0] NOP = 0, LDI = 1, LOAD = 2, STORE = 3, ADD = 4, SUB = 5,
                         PUT = 6, GET = 7, MASK = 8, ROUTE = 9;

  logic clk = 0, rst_n = 0;
  logic valid = 0, dir = 0;
  logic [3:0] op = 0, addr = 0, hops = 0;
  logic [1:0] lane = 0, mmode = 0;
  logic [63:0] imm = 0;
  logic [N-1:0] mvec = 0;
  logic ready, done;
  logic [N-1:0] active;
  logic [BW-1:0] acc_v, rr_v;

  int checks = 0, fails = 0;
  logic [63:0] m_acc [N], m_rr [N], m_mem [N][16];
  logic [N-1:0] m_act;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #10 clk = ~clk;

  simd_array uut (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(valid), .instr_ready_o(ready),
    .instr_op_i(op), .lane_i(lane), .addr_i(addr), .imm_i(imm), .mask_mode_i(mmode),
    .mask_vec_i(mvec), .route_dir_i(dir), .route_hops_i(hops), .done_o(done),
    .active_o(active), .acc_o(acc_v), .route_o(rr_v)
  );

  function automatic logic [63:0] rnd();
    seed ^= seed << 13; seed ^= seed >> 7; seed ^= seed << 17;
    return seed;
  endfunction

  function automatic logic [63:0] lane_op(logic [63:0] a, logic [63:0] b, logic sub, logic [1:0] ln);
    int w;
    logic [63:0] r, msk, ra, rb;
    w = (ln == 1) ? 32 : (ln == 2) ? 8 : 64;
    if (w == 64) return sub ? a - b : a + b;
    r = 0;
    msk = (64'd1 << w) - 1;
    for (int l = 0; l < 64 / w; l++) begin
      ra = (a >> (l * w)) & msk;
      rb = (b >> (l * w)) & msk;
      r |= ((sub ? ra - rb : ra + rb) & msk) << (l * w);
    end
    return r;
  endfunction

  task automatic check(string tag, logic [BW-1:0] got, logic [BW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic compare(string tag);
    logic [BW-1:0] ea, er;
    for (int p = 0; p < N; p++) begin
      ea[p*64 +: 64] = m_acc[p];
      er[p*64 +: 64] = m_rr[p];
    end
    check({tag, " acc"}, acc_v, ea);
    check({tag, " route"}, rr_v, er);
    check({tag, " active"}, BW'(active), BW'(m_act));
  endtask

  task automatic run(logic [3:0] o, logic [1:0] ln, logic [3:0] ad, logic [63:0] im,
                     logic [1:0] mm, logic [N-1:0] mv, logic dr, logic [3:0] hp, string tag);
    int n, exp_n;
    logic [63:0] tmp [N];
    @(negedge clk);
    op = o; lane = ln; addr = ad; imm = im; mmode = mm; mvec = mv; dir = dr; hops = hp;
    valid = 1;
    @(negedge clk);
    valid = 0;
    n = 1;
    while (!done && n < 64) begin @(negedge clk); n++; end
    // model
    if (o == MASK) begin
      for (int p = 0; p < N; p++)
        m_act[p] = (mm == 0) ? mv[p] : (mm == 1) ? (m_acc[p] == 0) : (mm == 2) ? m_acc[p][63] : 1'b1;
    end else if (o == ROUTE) begin
      for (int h = 0; h < hp; h++) begin
        for (int p = 0; p < N; p++) tmp[p] = m_rr[p];
        for (int p = 0; p < N; p++) m_rr[p] = dr ? tmp[(p + N - 1) % N] : tmp[(p + 1) % N];
      end
    end else begin
      for (int p = 0; p < N; p++) if (m_act[p]) begin
        case (o)
          LDI:   m_acc[p] = im;
          LOAD:  m_acc[p] = m_mem[p][ad];
          STORE: m_mem[p][ad] = m_acc[p];
          ADD:   m_acc[p] = lane_op(m_acc[p], m_mem[p][ad], 1'b0, ln);
          SUB:   m_acc[p] = lane_op(m_acc[p], m_mem[p][ad], 1'b1, ln);
          PUT:   m_rr[p] = m_acc[p];
          GET:   m_acc[p] = m_rr[p];
          default: ;
        endcase
      end
    end
    exp_n = (o == ROUTE && hp > 1) ? int'(hp) : 1;
    check({tag, " R6 done cycles"}, BW'(n), BW'(exp_n));
    compare(tag);
  endtask

  task automatic load_distinct(logic [3:0] ad);
    for (int p = 0; p < N; p++) begin
      run(MASK, 0, 0, 0, 0, N'(1) << p, 0, 0, "R7 vec");
      run(LDI, 0, 0, rnd(), 0, 0, 0, 0, "R2 ldi");
    end
    run(MASK, 0, 0, 0, 3, 0, 0, 0, "R7 all");
    run(STORE, 0, ad, 0, 0, 0, 0, 0, "R8 store");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] pats [6];
    for (int p = 0; p < N; p++) begin
      m_acc[p] = 0; m_rr[p] = 0;
      for (int a = 0; a < 16; a++) m_mem[p][a] = 0;
    end
    m_act = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 acc", acc_v, '0);
    check("R1 route", rr_v, '0);
    check("R1 active", BW'(active), BW'({N{1'b1}}));
    check("R1 ready", BW'(ready), BW'(1));
    check("R1 done", BW'(done), '0);

    // R8 per-PE stores, then read every word back
    for (int a = 0; a < 14; a++) load_distinct(4'(a));
    run(LDI, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, "R2 ldi");
    run(STORE, 0, 14, 0, 0, 0, 0, 0, "R8 store");
    run(LDI, 0, 0, 64'h0000_0001_0101_0101, 0, 0, 0, 0, "R2 ldi");
    run(STORE, 0, 15, 0, 0, 0, 0, 0, "R8 store");
    for (int a = 0; a < 16; a++) begin
      run(LDI, 0, 0, 0, 0, 0, 0, 0, "R2 clear");
      run(LOAD, 0, 4'(a), 0, 0, 0, 0, 0, "R8 load");
    end

    // R3 lane sweep with carry-boundary patterns
    pats[0] = 0; pats[1] = 64'hFFFF_FFFF_FFFF_FFFF; pats[2] = 64'h8000_0000_8000_0000;
    pats[3] = 64'h0000_0000_FFFF_FFFF; pats[4] = 64'h7F7F_7F7F_FFFF_FF01; pats[5] = rnd();
    for (int ln = 0; ln < 4; ln++)
      for (int k = 0; k < 6; k++) begin
        run(LDI, 0, 0, pats[k], 0, 0, 0, 0, "R2 ldi");
        for (int a = 0; a < 16; a++) begin
          run(ADD, 2'(ln), 4'(a), 0, 0, 0, 0, 0, "R3 add");
          run(SUB, 2'(ln), 4'((a * 7) % 16), 0, 0, 0, 0, 0, "R3 sub");
        end
      end

    // R7 condition masks
    run(LOAD, 0, 3, 0, 0, 0, 0, 0, "R2 load");
    run(MASK, 0, 0, 0, 2, 0, 0, 0, "R7 negative");
    run(LDI, 0, 0, 0, 0, 0, 0, 0, "R4 ldi masked");
    run(MASK, 0, 0, 0, 1, 0, 0, 0, "R7 zero");
    run(MASK, 0, 0, 0, 3, 0, 0, 0, "R7 all");

    // R4 inactive PEs frozen
    run(LOAD, 0, 5, 0, 0, 0, 0, 0, "R2 load");
    run(PUT, 0, 0, 0, 0, 0, 0, 0, "R2 put");
    run(MASK, 0, 0, 0, 0, 8'h5A, 0, 0, "R7 vec");
    run(LDI, 0, 0, 64'hDEAD_BEEF_0BAD_F00D, 0, 0, 0, 0, "R4 ldi");
    run(ADD, 2, 7, 0, 0, 0, 0, 0, "R4 add");
    run(SUB, 1, 9, 0, 0, 0, 0, 0, "R4 sub");
    run(STORE, 0, 2, 0, 0, 0, 0, 0, "R4 store");
    run(STORE, 0, 6, 0, 0, 0, 0, 0, "R4 store");
    run(PUT, 0, 0, 0, 0, 0, 0, 0, "R4 put");
    run(LOAD, 0, 11, 0, 0, 0, 0, 0, "R4 load");
    run(NOP, 0, 0, 0, 0, 0, 0, 0, "R2 nop");
    run(4'd12, 0, 0, 64'h1, 0, 0, 0, 0, "R2 unused op");

    // R5 R6 multi-hop routes across inactive PEs
    for (int h = 0; h < 12; h++) begin
      run(ROUTE, 0, 0, 0, 0, 0, 1'(h % 2), 4'(h), "R5 route");
      run(ROUTE, 0, 0, 0, 0, 0, 1'((h + 1) % 2), 4'(h + 3), "R5 route");
    end
    run(ROUTE, 0, 0, 0, 0, 0, 1, 15, "R5 route max");
    run(GET, 0, 0, 0, 0, 0, 0, 0, "R4 get masked");

    // R4 R8 memory of inactive PEs untouched
    run(MASK, 0, 0, 0, 3, 0, 0, 0, "R7 all");
    run(GET, 0, 0, 0, 0, 0, 0, 0, "R2 get");
    for (int a = 0; a < 16; a++) run(LOAD, 0, 4'(a), 0, 0, 0, 0, 0, "R4 reload");
    finish_run();
  end
endmodule